// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies two 32-bit operands and returns the low 32 bits of the product. An optional addend can be folded in, which gives the low half of a*b+c. It retires one multiplier bit in its first step and two bits in each later step. It stops as soon as the unconsumed part of the multiplier is zero, so short multipliers finish early. The worst case is 16 steps.

A caller holds `start` high with the operands valid. The operands are taken on the first rising edge at which the block is idle. `busy` stays high while more steps remain. `done` then pulses for one cycle, with `result` and `step_count` valid. Both outputs keep their values until the next accepted start. `step_count` is meant to feed a performance counter.

Top module: `mul_early_term`

## Requirements
- R1: When the operation finishes, `result` equals (op_a*op_b) mod 2^32, sampled at the accepting edge, plus op_c when `acc_en` is 1.
- R2: When `acc_en` is 0, `op_c` has no effect on `result`.
- R3: Let h be the bit position of the highest set bit of op_b, with h=0 when op_b is 0. The latency L, counted in rising edges from the accepting edge through the edge after which `done` is seen, equals min(16, floor((h+1)/2)+1). This gives 1 for op_b of 0 or 1, 2 for h of 1 or 2, and so on. `step_count` equals L while `done` is high.
- R4: `done` is high for exactly one cycle per accepted operation, and `busy` is low in that cycle.
- R5: The latency is capped at 16 cycles. Every op_b with h of 29, 30 or 31 takes exactly 16 cycles, and the product is still exact.
- R6: After the accepting edge, `busy` is high for exactly L-1 cycles and then `done` rises. An operation with L=1 never raises `busy`.
- R7: A `start` request, or a change of any operand, made while `busy` is high is ignored. The running operation's result and latency are unchanged.
- R8: `result` and `step_count` hold their values after `done` until the next start is accepted. After reset, `busy`, `done`, `result` and `step_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; taken when idle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier; its highest set bit sets the latency |
| op_c | input | 32 | Addend |
| acc_en | input | 1 | Adds op_c to the product when 1 |
| busy | output | 1 | More steps remain |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the product, or of product plus addend |
| step_count | output | 5 | Cycles taken by the last operation |

## Verification
The hardest case to reach is the final capped step. There the three top multiplier bits must be retired together, and only a multiplier whose highest set bit lies at position 29, 30 or 31 gets there. The stimulus sweeps the highest set bit through all 32 positions. For each position it uses a lone bit, a solid run of ones up to that bit, and a random fill. Each case runs with and without the addend. Some runs also assert `start` and scramble the operands during the busy window, which checks that the running operation is left alone.

// File: rtl/mul_early_term.sv
module mul_early_term #(
  parameter int W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [W-1:0]                  op_a,
  input  logic [W-1:0]                  op_b,
  input  logic [W-1:0]                  op_c,
  input  logic                          acc_en,
  output logic                          busy,
  output logic                          done,
  output logic [W-1:0]                  result,
  output logic [$clog2(W/2+1)-1:0]      step_count
);
  localparam int CAP = W / 2;
  localparam int CW  = $clog2(CAP + 1);

  logic [W-1:0]  sum_q, mcand_q, mplier_q;
  logic [CW-1:0] step_q;
  logic          run_q, done_q;

  wire           accept     = start && !run_q;
  wire [W-1:0]   seed       = acc_en ? op_c : '0;
  wire [W-1:0]   first_sum  = seed + (op_b[0] ? op_a : '0);
  wire [W-1:0]   first_rest = op_b >> 1;

  wire           last_step  = (step_q == CW'(CAP - 1));
  wire [W-1:0]   pp0        = mplier_q[0] ? mcand_q : '0;
  wire [W-1:0]   pp1        = mplier_q[1] ? (mcand_q << 1) : '0;
  wire [W-1:0]   pp2        = (last_step && mplier_q[2]) ? (mcand_q << 2) : '0;
  wire [W-1:0]   step_sum   = sum_q + pp0 + pp1 + pp2;
  wire [W-1:0]   step_rest  = mplier_q >> 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      step_q   <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        sum_q    <= first_sum;
        mcand_q  <= op_a << 1;
        mplier_q <= first_rest;
        step_q   <= CW'(1);
        if (first_rest == '0) done_q <= 1'b1;
        else                  run_q  <= 1'b1;
      end else if (run_q) begin
        sum_q    <= step_sum;
        mcand_q  <= mcand_q << 2;
        mplier_q <= step_rest;
        step_q   <= step_q + CW'(1);
        if (step_rest == '0 || last_step) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy       = run_q;
  assign done       = done_q;
  assign result     = sum_q;
  assign step_count = step_q;

  a_r5_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step_count != '0 && step_count <= CW'(CAP)));

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r3_short_op_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy)) |-> step_count == CW'(1));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> step_count == $past(step_count) + CW'(1));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !$past(start)) |-> ($stable(result) && $stable(step_count)));
endmodule

// File: tb/tb_mul_early_term.sv
module tb_mul_early_term;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] op_a = 0, op_b = 0, op_c = 0;
  logic        acc_en = 0;
  logic        busy, done;
  logic [31:0] result;
  logic [4:0]  step_count;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  mul_early_term dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .acc_en(acc_en), .busy(busy), .done(done),
    .result(result), .step_count(step_count)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [31:0] b);
    int h = 0;
    int l;
    for (int i = 0; i < 32; i++) if (b[i]) h = i;
    l = (h + 1) / 2 + 1;
    if (l > 16) l = 16;
    return l;
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input bit en, input bit disturb);
    logic [31:0] exp_r;
    int          exp_l, n;
    bit          busy_ok;
    logic [31:0] r_hold;
    logic [4:0]  s_hold;
    exp_r = a * b + (en ? c : 32'd0);
    exp_l = exp_lat(b);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; acc_en = en; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    busy_ok = 1;
    while (!done && n < 40) begin
      if (!busy) busy_ok = 0;
      if (disturb) begin
        start = 1; op_a = ~a; op_b = 32'hFFFF_FFFF; op_c = ~c; acc_en = ~en;
      end
      @(negedge clk);
      start = 0;
      n++;
    end
    chk(n == exp_l, "R3/R5 latency", n, exp_l);
    chk(step_count == exp_l[4:0], "R3 step_count", {27'd0, step_count}, exp_l);
    chk(result == exp_r, en ? "R1 result with addend" : "R1/R2 result, addend off", result, exp_r);
    chk(busy_ok && !busy, "R4/R6 busy window", {31'd0, busy}, 0);
    if (disturb) chk(result == exp_r, "R7 start while busy ignored", result, exp_r);
    r_hold = result;
    s_hold = step_count;
    op_a = 32'h1234_5678; op_b = 32'h0F0F_0F0F; op_c = 32'h5555_AAAA;
    @(negedge clk);
    chk(!done, "R4 done single pulse", {31'd0, done}, 0);
    @(negedge clk);
    chk(result == r_hold && step_count == s_hold, "R8 outputs hold", result, r_hold);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R8 reset flags", {30'd0, busy, done}, 0);
    chk(result == 0 && step_count == 0, "R8 reset outputs", result, 0);
    rst_n = 1;
    @(negedge clk);
    run_op(32'hDEAD_BEEF, 32'd0, 32'h1111_1111, 1, 0);
    run_op(32'hDEAD_BEEF, 32'd0, 32'h1111_1111, 0, 0);
    run_op(32'h0000_0007, 32'd1, 32'd0, 0, 0);
    for (int h = 0; h < 32; h++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] b;
        logic [31:0] a;
        logic [31:0] c;
        a = $urandom;
        c = $urandom;
        if (k == 0) b = 32'd1 << h;
        else if (k == 1) b = (h == 31) ? 32'hFFFF_FFFF : ((32'd1 << (h + 1)) - 1);
        else b = (32'd1 << h) | ($urandom & ((32'd1 << h) - 1));
        run_op(a, b, c, 0, (k == 2));
        run_op(a, b, c, 1, (k == 1));
      end
    end
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    run_op(32'h8000_0001, 32'h4000_0000, 32'd0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule